// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

One channel of a peripheral timer. A 32-bit counter steps down once per prescaled count pulse while the shared run input is high. When a step is taken with the counter already at zero, the counter reloads from a reload register and a sticky underflow flag is set. The interrupt request is the level of that flag ANDed with an interrupt enable bit in the control register.

Software reaches the channel through a plain word-wide register port. The port has a select, a write strobe, a 2-bit register index and write data, and it returns read data combinationally. It has no back-pressure. A write completes on the clock edge where select and write are both high, and read data is valid in any cycle where select is high. Reserved encodings are tolerated. Unused prescale codes stop the count. The clock-edge and capture-control fields are stored and read back but have no effect. The capture index always reads zero.

Register indices are: 0 the reload value, 1 the counter, 2 the control word, 3 capture. Control word fields are: bits [2:0] prescale code, bits [4:3] edge select, bit 5 underflow interrupt enable, bits [7:6] capture control, and bit 8 underflow flag.

Top module: `dctmr_channel`

## Requirements
- R1: After reset the reload register and the counter read 0xFFFFFFFF, the control word reads 0 and irq is low.
- R2: With prescale code 0, 1, 2, 3 or 4 (control bits [2:0]) and run high, the counter decreases by one every 4, 16, 64, 256 or 1024 clock cycles respectively.
- R3: Prescale codes 5, 6 and 7 produce no count pulses, so the counter holds. The edge select field (bits [4:3]) and the capture control field (bits [7:6]) do not change the count rate.
- R4: While run is low the counter holds and the underflow flag is not set.
- R5: A count pulse taken with the counter at zero loads the counter with the reload value and sets the underflow flag.
- R6: A control write with bit 8 at 0 clears the underflow flag. A control write with bit 8 at 1 leaves the flag unchanged. Software cannot set the flag.
- R7: Reading index 2 returns the last written control bits [7:0], the live underflow flag at bit 8, and zero in bits [31:9].
- R8: irq is high exactly when the underflow flag and the interrupt enable bit 5 are both set.
- R9: A control write suppresses counting on its own edge and restarts the prescaler, so the first count pulse after it comes a full ratio of cycles later.
- R10: Writes to index 0 and index 1 load the reload value and the counter and read back unchanged. A counter write takes precedence over a count pulse on the same edge.
- R11: Index 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Count enable from the shared start register |
| reg_sel | input | 1 | Register access select |
| reg_we | input | 1 | Write strobe, qualified by reg_sel |
| reg_idx | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when reg_sel is low |
| irq | output | 1 | Underflow interrupt request level |

## Verification
The bench builds the channel with its default parameters: a 32-bit counter, an all-ones reload reset value, and the five-ratio prescaler. This makes every ratio reachable, up to 1024, within a few thousand cycles. Small loaded counts and a small reload value bring underflow, reload and the flag rules within tens of cycles. Because each control write restarts the prescaler, the expected count after N cycles is the start value minus N divided by the ratio, rounded down. This makes the pause rule and the ratio boundaries directly observable at the register port.

// File: rtl/dctmr_pkg.sv
package dctmr_pkg;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } reg_idx_e;

  // Stored control bits, LSB first in position: psc [2:0], edge [4:3], ie [5], capt [7:6]
  typedef struct packed {
    logic [1:0] capt;
    logic       ie;
    logic [1:0] edge_sel;
    logic [2:0] psc;
  } ctrl_t;

  localparam int CTRL_KEEP_W = $bits(ctrl_t);
  localparam int UF_BIT      = 8;
  localparam int PSC_SEL_W   = 3;
  localparam int NUM_RATIOS  = 5;
  localparam int STEP_LOG2   = 2;

endpackage

// File: rtl/dctmr_prescale.sv
module dctmr_prescale #(
  parameter int NUM_RATIOS = 5,
  parameter int STEP_LOG2  = 2,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int DIV_W = NUM_RATIOS * STEP_LOG2;

  logic [DIV_W-1:0]      div_q;
  logic [NUM_RATIOS-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  // ratio for code g is 2**(STEP_LOG2*(g+1))
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_ratio
    assign hit[g] = &div_q[(g+1)*STEP_LOG2-1:0];
  end

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (sel == SEL_W'(i)) tick = hit[i];
    end
  end

  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/dctmr_counter.sv
module dctmr_counter #(
  parameter int             W         = 32,
  parameter logic [W-1:0]   INIT_VAL  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         hold,
  input  logic         ld_cnt,
  input  logic         ld_rel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rel_q,
  output logic         uf
);

  logic step;

  always_comb begin
    step = tick && run && !hold;
    uf   = step && !ld_cnt && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q <= INIT_VAL;
      cnt_q <= INIT_VAL;
    end else begin
      if (ld_rel) rel_q <= wdata;
      if (ld_cnt)    cnt_q <= wdata;
      else if (uf)   cnt_q <= rel_q;
      else if (step) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_cnt && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> cnt_q == $past(rel_q));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_cnt) |=> $stable(cnt_q));

  // R9
  write_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ld_cnt) |=> $stable(cnt_q));

endmodule

// File: rtl/dctmr_ctrl.sv
module dctmr_ctrl
  import dctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [UF_BIT:0]   wbits,
  input  logic              uf,
  output ctrl_t             ctrl_q,
  output logic              flag_q,
  output logic              irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (we) ctrl_q <= ctrl_t'(wbits[CTRL_KEEP_W-1:0]);
      if (we && !wbits[UF_BIT]) flag_q <= 1'b0;
      else if (uf)              flag_q <= 1'b1;
    end
  end

  assign irq = flag_q && ctrl_q.ie;

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wbits[UF_BIT]) |=> !flag_q);

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wbits[UF_BIT] && !uf) |=> flag_q == $past(flag_q));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !(we && !wbits[UF_BIT])) |=> flag_q);

  // R6
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(uf));

endmodule

// File: rtl/dctmr_channel.sv
module dctmr_channel
  import dctmr_pkg::*;
#(
  parameter int              CNT_W       = 32,
  parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [1:0]       reg_idx,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);

  logic             wr_rel, wr_cnt, wr_ctrl, wr_capt;
  logic             tick, uf, flag_q;
  logic [CNT_W-1:0] cnt_q, rel_q;
  ctrl_t            ctrl_q;

  always_comb begin
    wr_rel  = reg_sel && reg_we && (reg_idx == REG_RELOAD);
    wr_cnt  = reg_sel && reg_we && (reg_idx == REG_COUNT);
    wr_ctrl = reg_sel && reg_we && (reg_idx == REG_CTRL);
    wr_capt = reg_sel && reg_we && (reg_idx == REG_CAPT);
  end

  dctmr_prescale #(
    .NUM_RATIOS (NUM_RATIOS),
    .STEP_LOG2  (STEP_LOG2),
    .SEL_W      (PSC_SEL_W)
  ) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_ctrl),
    .sel     (ctrl_q.psc),
    .tick    (tick)
  );

  dctmr_counter #(
    .W        (CNT_W),
    .INIT_VAL (RELOAD_INIT)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (run),
    .hold   (wr_ctrl),
    .ld_cnt (wr_cnt),
    .ld_rel (wr_rel),
    .wdata  (reg_wdata),
    .cnt_q  (cnt_q),
    .rel_q  (rel_q),
    .uf     (uf)
  );

  dctmr_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_ctrl),
    .wbits  (reg_wdata[UF_BIT:0]),
    .uf     (uf),
    .ctrl_q (ctrl_q),
    .flag_q (flag_q),
    .irq    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      case (reg_idx)
        REG_RELOAD: reg_rdata = rel_q;
        REG_COUNT:  reg_rdata = cnt_q;
        REG_CTRL: begin
          reg_rdata[CTRL_KEEP_W-1:0] = ctrl_q;
          reg_rdata[UF_BIT]          = flag_q;
        end
        default:    reg_rdata = '0;
      endcase
    end
  end

  // R11
  capt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_capt |=> ($stable(rel_q) && $stable(ctrl_q)));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && ctrl_q.ie));

endmodule

// File: tb/tb_dctmr_channel.sv
`timescale 1ns/1ps
module tb_dctmr_channel;

  localparam time TCK = 8ns;

  logic        clk = 1'b0;
  logic        rst_n, run, reg_sel, reg_we, irq;
  logic [1:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(TCK/2) clk = ~clk;

  dctmr_channel dut (
    .clk(clk), .rst_n(rst_n), .run(run), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] rel;
    logic [31:0] start;
    logic [31:0] n;
    logic [31:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h00, 32'h100, 32'd100, 32'd40,   32'd90,  1'b0}, // R2 ratio 4
    '{32'h00, 32'h100, 32'd100, 32'd43,   32'd90,  1'b0}, // R2 partial
    '{32'h00, 32'h100, 32'd7,   32'd3,    32'd7,   1'b0}, // R2 boundary
    '{32'h01, 32'h100, 32'd50,  32'd64,   32'd46,  1'b0}, // R2 ratio 16
    '{32'h02, 32'h100, 32'd10,  32'd200,  32'd7,   1'b0}, // R2 ratio 64
    '{32'h03, 32'h100, 32'd10,  32'd600,  32'd8,   1'b0}, // R2 ratio 256
    '{32'h04, 32'h100, 32'd5,   32'd2100, 32'd3,   1'b0}, // R2 ratio 1024
    '{32'h05, 32'h100, 32'd20,  32'd300,  32'd20,  1'b0}, // R3 code 5
    '{32'h07, 32'h100, 32'd0,   32'd300,  32'd0,   1'b0}, // R3 code 7
    '{32'h18, 32'h100, 32'd100, 32'd40,   32'd90,  1'b0}, // R3 edge field
    '{32'hC1, 32'h100, 32'd50,  32'd64,   32'd46,  1'b0}, // R3 capture field
    '{32'h00, 32'h100, 32'd2,   32'd12,   32'h100, 1'b1}, // R5 reload
    '{32'h00, 32'h100, 32'd1,   32'd16,   32'hFE,  1'b1}, // R5 after reload
    '{32'h01, 32'h40,  32'd0,   32'd32,   32'h3F,  1'b1}  // R5 ratio 16
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    reg_sel = 1'b1; reg_we = 1'b0; reg_idx = idx;
    #1;
    d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; run = 1'b0; reg_sel = 1'b0; reg_we = 1'b0;
    reg_idx = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 reload", d, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R1 count", d, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R1 ctrl", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R4 run low
    wr(2'd0, 32'h100);
    wr(2'd1, 32'd30);
    wr(2'd2, 32'h00);
    wait_edges(40);
    rd(2'd1, d); chk("R4 count held", d, 32'd30);
    rd(2'd2, d); chk("R4 no flag", d, 32'h0);

    // table walk: R2 R3 R5 R7
    run = 1'b1;
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i].rel);
      wr(2'd1, VEC[i].start);
      wr(2'd2, VEC[i].ctrl);
      wait_edges(int'(VEC[i].n));
      rd(2'd1, d); chk("R2/R3/R5 count", d, VEC[i].exp_cnt);
      rd(2'd2, d);
      chk("R5 flag", {31'd0, d[8]}, {31'd0, VEC[i].exp_flag});
      chk("R7 ctrl bits", {24'd0, d[7:0]}, VEC[i].ctrl);
    end

    // R9 control write pauses and restarts the prescaler
    wr(2'd1, 32'd100);
    wr(2'd2, 32'h00);
    wait_edges(3);
    wr(2'd2, 32'h00);
    wait_edges(3);
    rd(2'd1, d); chk("R9 paused", d, 32'd100);
    wait_edges(1);
    rd(2'd1, d); chk("R9 resumed", d, 32'd99);

    // R5 R6 R8 flag and interrupt
    wr(2'd0, 32'h100);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'h20);
    wait_edges(4);
    chk("R8 irq set", {31'd0, irq}, 32'd1);
    rd(2'd2, d); chk("R7 ctrl with flag", d, 32'h120);
    wr(2'd2, 32'h120);
    chk("R6 keep flag irq", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h100);
    chk("R8 enable off", {31'd0, irq}, 32'd0);
    rd(2'd2, d); chk("R6 flag kept", d, 32'h100);
    wr(2'd2, 32'h020);
    rd(2'd2, d); chk("R6 flag cleared", d, 32'h020);
    chk("R8 irq low", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'hFFFF_FEFF);
    rd(2'd2, d); chk("R6/R7 no sw set", d, 32'h0FF);

    // R10 R11 register access
    wr(2'd0, 32'h1234_5678);
    rd(2'd0, d); chk("R10 reload rw", d, 32'h1234_5678);
    run = 1'b0;
    wr(2'd1, 32'hCAFE_0001);
    rd(2'd1, d); chk("R10 count rw", d, 32'hCAFE_0001);
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, d); chk("R11 capt reads 0", d, 32'h0);
    rd(2'd0, d); chk("R11 reload untouched", d, 32'h1234_5678);
    rd(2'd2, d); chk("R11 ctrl untouched", d, 32'h0FF);

    finish_run();
  end

endmodule